// File: doc/BRIEF.md
# Programmable Delay Tap Controller

This block holds the 5-bit tap setting that decides how many sampling-clock stages an incoming bit is held back, and changes that setting from a small set of control inputs sampled on one control clock. The tap can be stepped up or down by one position, with wrap at both ends. It can also be loaded from one of three sources, picked at elaboration: a static initial-tap parameter, the live count input, or a pipeline register that captured the count input earlier. The current tap is always visible on a count output.

A clocked stand-in for the analog delay line is included. A 32-stage shift chain samples either a pad-side bit or a fabric-side bit on a sampling clock. The fabric-side bit can be inverted by parameter. The delayed output is the chain stage indexed by the current tap. Surrounding logic uses the block to train a sampling point: it loads a starting tap and nudges it while watching the delayed data.

Top module: `dly_tap_ctrl`

## Requirements
- R1: While reset is low, the count output and the pipeline register hold INIT_TAP, and every delay-chain stage holds 0.
- R2: With MODE set to fixed, a high ld at a control-clock edge sets the tap to INIT_TAP.
- R3: With MODE set to direct, a high ld at a control-clock edge copies cnt_in into the tap.
- R4: With MODE set to pipelined, a high ld at a control-clock edge copies the pipeline register into the tap and ignores the live cnt_in.
- R5: A high pipe_en at a control-clock edge captures cnt_in into the pipeline register whatever ld does. When capture and load happen in the same cycle, the tap receives the value the pipeline register held before that edge.
- R6: With ld low and ce high, the tap rises by one when inc is 1 and falls by one when inc is 0, wrapping from 31 to 0 and from 0 to 31.
- R7: When ld and ce are both high in the same cycle, the load is taken and the step is discarded.
- R8: With ld and ce both low, the tap keeps its value, whatever pipe_en, inc and cnt_in do.
- R9: After each sampling-clock edge, dly_out equals the source bit captured k edges earlier, where k is the current tap. k = 0 means the bit captured at that same edge.
- R10: The source bit is pad_in when src_fab is 0. It is fab_in when src_fab is 1, inverted when FAB_INV is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ctrl | input | 1 | Control clock; all control inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for tap, pipeline register and delay chain |
| ld | input | 1 | Active-high load of the tap from the mode's load source |
| ce | input | 1 | Step enable for the tap |
| inc | input | 1 | Step direction: 1 up, 0 down |
| pipe_en | input | 1 | Captures cnt_in into the pipeline register |
| cnt_in | input | TAP_W | Tap value input for direct load and pipeline capture |
| cnt_out | output | TAP_W | Current tap |
| clk_smp | input | 1 | Sampling clock of the delay chain |
| src_fab | input | 1 | Source select: 0 pad side, 1 fabric side |
| pad_in | input | 1 | Pad-side data bit |
| fab_in | input | 1 | Fabric-side data bit |
| dly_out | output | 1 | Delayed data bit |

## Verification
The bench builds three copies side by side from the same stimulus. The first runs pipelined mode with INIT_TAP 0 and no inversion. The second runs fixed mode with INIT_TAP 5 and FAB_INV 1, so a load to the initial tap cannot be mistaken for a reset to zero, and a dropped inversion shows up on the delayed data. The third runs direct mode, where cnt_in reaches the tap with no pipeline register in between. Both clocks are tied together, so a tap change and the next data sample happen on the same edge and the selected stage can be predicted exactly.

// File: rtl/dly_tap_pkg.sv
package dly_tap_pkg;

    // Source of the value taken by a load
    typedef enum logic [1:0] {
        TAP_MODE_FIXED  = 2'd0,  // static initial-tap parameter
        TAP_MODE_DIRECT = 2'd1,  // live count input
        TAP_MODE_PIPE   = 2'd2   // captured pipeline register
    } tap_mode_e;

endpackage

// File: rtl/tap_pipe_reg.sv
module tap_pipe_reg #(
    parameter int W        = 5,
    parameter int INIT_TAP = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic [W-1:0] cap_val,
    output logic [W-1:0] pipe_q
);
    localparam logic [W-1:0] INIT_V = W'(INIT_TAP);

    typedef struct packed {
        logic [W-1:0] val;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_en) begin
            st_d.val = cap_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.val <= INIT_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign pipe_q = st_q.val;

    // R5: capture follows the count input by one edge
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> pipe_q == $past(cap_val));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(pipe_q));

endmodule

// File: rtl/tap_counter.sv
module tap_counter #(
    parameter int W        = 5,
    parameter int INIT_TAP = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         ce,
    input  logic         inc,
    output logic [W-1:0] tap_q
);
    localparam logic [W-1:0] INIT_V = W'(INIT_TAP);
    localparam logic [W-1:0] ONE    = W'(1);

    typedef struct packed {
        logic [W-1:0] tap;
    } tap_st_t;

    tap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.tap = ld_val;
        end else if (ce) begin
            // modular arithmetic in W bits gives the wrap at both ends
            st_d.tap = inc ? (st_q.tap + ONE) : (st_q.tap - ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tap <= INIT_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign tap_q = st_q.tap;

    // R1: reset value
    a_r1_reset_tap: assert property (@(posedge clk)
        !rst_n |=> tap_q == INIT_V);

    // R7: load wins over step
    a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> tap_q == $past(ld_val));

    // R6: step up and down with wrap
    a_r6_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && ce && inc) |=> tap_q == $past(tap_q) + ONE);

    a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && ce && !inc) |=> tap_q == $past(tap_q) - ONE);

    // R8: idle holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !ce) |=> $stable(tap_q));

endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
    parameter int W       = 5,
    parameter bit FAB_INV = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_fab,
    input  logic         pad_in,
    input  logic         fab_in,
    input  logic [W-1:0] tap,
    output logic         dly_o
);
    localparam int DEPTH = 2 ** W;
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [DEPTH-1:0] chain;
    } dl_st_t;

    dl_st_t st_d, st_q;
    logic   src_bit;

    always_comb begin
        src_bit  = sel_fab ? (fab_in ^ FAB_INV) : pad_in;
        st_d     = st_q;
        st_d.chain = {st_q.chain[DEPTH-2:0], src_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dly_o = st_q.chain[tap];

    // R9: with a steady nonzero tap, the output is the previous cycle's
    // neighbour stage
    a_r9_select: assert property (@(posedge clk) disable iff (!rst_n)
        (tap != '0 && $stable(tap)) |-> dly_o == $past(st_q.chain[tap - ONE]));

    // R10: pad side enters the chain when selected
    a_r10_pad_src: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_fab |=> st_q.chain[0] == $past(pad_in));

    a_r10_fab_src: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fab |=> st_q.chain[0] == ($past(fab_in) ^ FAB_INV));

endmodule

// File: rtl/dly_tap_ctrl.sv
module dly_tap_ctrl
    import dly_tap_pkg::*;
#(
    parameter tap_mode_e MODE     = TAP_MODE_PIPE,
    parameter int        TAP_W    = 5,
    parameter int        INIT_TAP = 0,
    parameter bit        FAB_INV  = 1'b0
) (
    input  logic             clk_ctrl,
    input  logic             rst_n,
    input  logic             ld,
    input  logic             ce,
    input  logic             inc,
    input  logic             pipe_en,
    input  logic [TAP_W-1:0] cnt_in,
    output logic [TAP_W-1:0] cnt_out,
    input  logic             clk_smp,
    input  logic             src_fab,
    input  logic             pad_in,
    input  logic             fab_in,
    output logic             dly_out
);
    localparam logic [TAP_W-1:0] INIT_V = TAP_W'(INIT_TAP);

    logic [TAP_W-1:0] pipe_val;
    logic [TAP_W-1:0] load_val;
    logic [TAP_W-1:0] tap_cur;

    tap_pipe_reg #(
        .W        (TAP_W),
        .INIT_TAP (INIT_TAP)
    ) u_pipe (
        .clk     (clk_ctrl),
        .rst_n   (rst_n),
        .cap_en  (pipe_en),
        .cap_val (cnt_in),
        .pipe_q  (pipe_val)
    );

    // load source picked at elaboration
    generate
        if (MODE == TAP_MODE_FIXED) begin : g_src_fixed
            assign load_val = INIT_V;
            // R2: load returns to the initial tap
            a_r2_fixed_load: assert property (@(posedge clk_ctrl) disable iff (!rst_n)
                ld |=> cnt_out == INIT_V);
        end else if (MODE == TAP_MODE_DIRECT) begin : g_src_direct
            assign load_val = cnt_in;
            // R3: load copies the live count input
            a_r3_direct_load: assert property (@(posedge clk_ctrl) disable iff (!rst_n)
                ld |=> cnt_out == $past(cnt_in));
        end else begin : g_src_pipe
            assign load_val = pipe_val;
            // R4: load copies the pipeline register as it stood before the edge
            a_r4_pipe_load: assert property (@(posedge clk_ctrl) disable iff (!rst_n)
                ld |=> cnt_out == $past(pipe_val));
        end
    endgenerate

    tap_counter #(
        .W        (TAP_W),
        .INIT_TAP (INIT_TAP)
    ) u_cnt (
        .clk    (clk_ctrl),
        .rst_n  (rst_n),
        .ld     (ld),
        .ld_val (load_val),
        .ce     (ce),
        .inc    (inc),
        .tap_q  (tap_cur)
    );

    tap_delay_line #(
        .W       (TAP_W),
        .FAB_INV (FAB_INV)
    ) u_dline (
        .clk     (clk_smp),
        .rst_n   (rst_n),
        .sel_fab (src_fab),
        .pad_in  (pad_in),
        .fab_in  (fab_in),
        .tap     (tap_cur),
        .dly_o   (dly_out)
    );

    assign cnt_out = tap_cur;

endmodule

// File: tb/dly_tap_ctrl_bench.sv
module dly_tap_ctrl_bench;
    import dly_tap_pkg::*;

    localparam int TW = 5;
    localparam int NT = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          rst_n   = 1'b0;
    logic          ld      = 1'b0;
    logic          ce      = 1'b0;
    logic          inc     = 1'b0;
    logic          pipe_en = 1'b0;
    logic [TW-1:0] cnt_in  = '0;
    logic          src_fab = 1'b0;
    logic          pad_in  = 1'b0;
    logic          fab_in  = 1'b0;

    logic [TW-1:0] cnt_o [3];
    logic          dly_o [3];

    // copy 0: pipelined, init 0, no inversion
    dly_tap_ctrl #(.MODE(TAP_MODE_PIPE), .TAP_W(TW), .INIT_TAP(0), .FAB_INV(1'b0)) u_dly_tap_ctrl (
        .clk_ctrl(clk), .rst_n(rst_n), .ld(ld), .ce(ce), .inc(inc), .pipe_en(pipe_en),
        .cnt_in(cnt_in), .cnt_out(cnt_o[0]), .clk_smp(clk), .src_fab(src_fab),
        .pad_in(pad_in), .fab_in(fab_in), .dly_out(dly_o[0]));

    // copy 1: fixed, init 5, inverted fabric input
    dly_tap_ctrl #(.MODE(TAP_MODE_FIXED), .TAP_W(TW), .INIT_TAP(5), .FAB_INV(1'b1)) u_dly_tap_ctrl_fix (
        .clk_ctrl(clk), .rst_n(rst_n), .ld(ld), .ce(ce), .inc(inc), .pipe_en(pipe_en),
        .cnt_in(cnt_in), .cnt_out(cnt_o[1]), .clk_smp(clk), .src_fab(src_fab),
        .pad_in(pad_in), .fab_in(fab_in), .dly_out(dly_o[1]));

    // copy 2: direct, init 0, no inversion
    dly_tap_ctrl #(.MODE(TAP_MODE_DIRECT), .TAP_W(TW), .INIT_TAP(0), .FAB_INV(1'b0)) u_dly_tap_ctrl_dir (
        .clk_ctrl(clk), .rst_n(rst_n), .ld(ld), .ce(ce), .inc(inc), .pipe_en(pipe_en),
        .cnt_in(cnt_in), .cnt_out(cnt_o[2]), .clk_smp(clk), .src_fab(src_fab),
        .pad_in(pad_in), .fab_in(fab_in), .dly_out(dly_o[2]));

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    bit    running = 1'b0;
    string phase  = "R8";

    // reference model
    int init_v [3] = '{0, 5, 0};
    bit inv_v  [3] = '{1'b0, 1'b1, 1'b0};
    int m_tap  [3];
    int m_pipe [3];
    bit m_hist [3][NT];

    always @(posedge clk or negedge rst_n) begin : ref_model
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin
                m_tap[k]  = init_v[k];
                m_pipe[k] = init_v[k];
                for (int j = 0; j < NT; j++) m_hist[k][j] = 1'b0;
            end
        end else begin
            for (int k = 0; k < 3; k++) begin
                int nxt;
                bit s;
                s = src_fab ? (fab_in ^ inv_v[k]) : pad_in;
                for (int j = NT - 1; j > 0; j--) m_hist[k][j] = m_hist[k][j-1];
                m_hist[k][0] = s;
                if (ld) begin
                    if (k == 0)      nxt = m_pipe[k];
                    else if (k == 1) nxt = init_v[k];
                    else             nxt = int'(cnt_in);
                end else if (ce) begin
                    nxt = inc ? (m_tap[k] + 1) % NT : (m_tap[k] + NT - 1) % NT;
                end else begin
                    nxt = m_tap[k];
                end
                if (pipe_en) m_pipe[k] = int'(cnt_in);
                m_tap[k] = nxt;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (running && rst_n) begin
            for (int k = 0; k < 3; k++) begin
                chk(phase, $sformatf("cnt_out[%0d]", k), int'(cnt_o[k]), m_tap[k]);
                chk("R9,R10", $sformatf("dly_out[%0d]", k), int'(dly_o[k]), int'(m_hist[k][m_tap[k]]));
            end
        end
    end

    task automatic drive(input bit l, input bit c, input bit i, input bit p, input int v);
        @(negedge clk);
        #1;
        ld      = l;
        ce      = c;
        inc     = i;
        pipe_en = p;
        cnt_in  = TW'(v);
        pad_in  = 1'($urandom);
        fab_in  = 1'($urandom);
        if (($urandom % 4) == 0) src_fab = ~src_fab;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "cnt_out pipe",   int'(cnt_o[0]), 0);
        chk("R1", "cnt_out fixed",  int'(cnt_o[1]), 5);
        chk("R1", "cnt_out direct", int'(cnt_o[2]), 0);
        chk("R1", "dly_out pipe",   int'(dly_o[0]), 0);
        #1;
        rst_n   = 1'b1;
        running = 1'b1;

        phase = "R8";
        repeat (3) drive(0, 0, 0, 0, 0);

        // R2, R3, R4: one load for all three sources
        phase = "R2,R3,R4";
        drive(1, 0, 0, 0, 29);
        drive(0, 0, 0, 0, 0);

        // R6: up across 31->0, then down across 0->31
        phase = "R6";
        repeat (5) drive(0, 1, 1, 0, 7);
        repeat (7) drive(0, 1, 0, 0, 7);

        // R5: capture, then capture and load together, then load alone
        phase = "R5";
        drive(0, 0, 0, 1, 17);
        drive(1, 0, 0, 1, 9);
        drive(0, 0, 0, 0, 0);
        phase = "R4";
        drive(1, 0, 0, 0, 2);
        drive(0, 0, 0, 0, 0);

        // R7: load and step together
        phase = "R7";
        drive(1, 1, 1, 0, 3);
        drive(1, 1, 0, 1, 30);
        drive(0, 0, 0, 0, 0);

        // R8: idle with pipe capture and count input changing
        phase = "R8";
        for (int n = 0; n < 6; n++) drive(0, 0, n[0], n[1], n * 5);

        // mixed traffic for every mode
        phase = "R6";
        for (int n = 0; n < 3000; n++) begin
            bit l;
            l = (($urandom % 16) == 0);
            drive(l, 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % NT));
        end

        drive(0, 0, 0, 0, 0);
        @(negedge clk);
        #2;
        finish_run();
    end

endmodule